// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block moves a small 8-bit core with a 16-bit program counter into an interrupt service routine and back out again. At each instruction boundary signalled by the core, it compares the pending request flags against the per-source enables, the global master-enable bit held in the status word, and a non-maskable request line. It then picks one winner by fixed priority. After accepting a request, it runs a fixed multi-cycle byte-bus sequence. It clears the winner's request flag and the master enable, pushes the return context onto a stack that grows downward, reads a two-byte little-endian vector, and loads the program counter.

The matching return sequence is started by a one-cycle strobe from the core. It pops the status word and the program counter in the reverse order of entry. `busy_o` stalls instruction fetch from the acceptance cycle until the program counter has been loaded. Only the program counter and the status word are saved. The block never writes general-purpose registers.

Memory reads are asynchronous: `mem_rdata_i` must be valid in the same cycle that `mem_rd_o` is high.

Top module: `intr_seq_top`

## Requirements
- R1: Reset behaviour.
  - While reset is held and right after it is released, `busy_o`, `mem_wr_o`, `mem_rd_o`, `pc_we_o`, `psw_we_o` and `sp_we_o` are all 0.
- R2: Conditions for accepting a request.
  - A request is accepted only in a cycle where `boundary_i` is 1 and the block is idle.
  - A maskable source k is eligible only when `req_i[k]`, `en_i[k]` and `psw_i[IME_BIT]` are all 1.
  - With the master enable at 0, or with `boundary_i` at 0, pending requests leave every output untouched.
- R3: Priority.
  - Among eligible maskable sources, the lowest index wins.
  - An accepted non-maskable request beats every maskable source.
- R4: Flag clearing.
  - In the first cycle after acceptance, exactly the winner's clear output pulses for one cycle: `req_clr_o[k]`, or `nmi_clr_o` for the non-maskable request.
  - No other source's flag is cleared.
- R5: Master enable on entry.
  - In that same cycle, `psw_we_o` writes the saved status word with bit `IME_BIT` forced to 0.
  - This happens for both maskable and non-maskable entry.
- R6: Context push.
  - In three consecutive cycles the block writes PC[15:8] at SP, then PC[7:0] at SP-1, then the original status word at SP-2.
  - Each of these writes pulses `sp_we_o`, with `sp_o` equal to the written address minus 1, so the final SP is SP-3.
- R7: Vector fetch.
  - After the pushes, the block reads address `VEC_BASE + 2*k` (low byte) and then the next address (high byte).
  - In the second read cycle, `pc_we_o` loads {high, low}.
  - The non-maskable request uses k = `N_SRC`.
  - With `VEC_BASE` = 0xFFE0, source 3, 0xFFE6 = 0x12 and 0xFFE7 = 0xE3, the loaded PC is 0xE312.
- R8: Entry busy window.
  - `busy_o` is high in the acceptance cycle and the five sequence cycles that follow, six cycles in all.
  - It falls in the cycle after `pc_we_o`.
- R9: Non-maskable lock.
  - After a non-maskable entry, a new non-maskable request is not accepted until a return sequence has completed.
  - Maskable sources still follow R2 during this time.
- R10: Return sequence.
  - From idle, `reti_i` reads the status word at SP+1, then the PC low byte at SP+2, then the high byte at SP+3.
  - It restores `psw_o` (including the saved master-enable bit), `pc_o` and SP+3, with `busy_o` high for four cycles.
- R11: A `reti_i` that arrives in the same idle cycle as an acceptable request takes precedence, and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Return-from-interrupt request strobe |
| nmi_i | input | 1 | Non-maskable request pending |
| req_i | input | N_SRC | Maskable request flags |
| en_i | input | N_SRC | Per-source enable flags |
| req_clr_o | output | N_SRC | One-cycle clear pulse for the accepted source flag |
| nmi_clr_o | output | 1 | One-cycle clear pulse for the non-maskable flag |
| pc_i | input | 2*DW | Current program counter |
| psw_i | input | DW | Current status word |
| sp_i | input | AW | Current stack pointer |
| pc_we_o | output | 1 | Program counter load strobe |
| pc_o | output | 2*DW | Program counter load value |
| psw_we_o | output | 1 | Status word load strobe |
| psw_o | output | DW | Status word load value |
| sp_we_o | output | 1 | Stack pointer load strobe |
| sp_o | output | AW | Stack pointer load value |
| mem_addr_o | output | AW | Byte bus address |
| mem_rd_o | output | 1 | Byte bus read |
| mem_wr_o | output | 1 | Byte bus write |
| mem_wdata_o | output | DW | Byte bus write data |
| mem_rdata_i | input | DW | Byte bus read data, valid in the read cycle |
| busy_o | output | 1 | Sequence in progress; stalls instruction fetch |

## Verification
Some properties are checked on every cycle:
- The clear pulses are one-hot and last one cycle, and each comes with a status-word write that drops the master enable.
- Consecutive push writes step down by one address.
- The stack pointer tracks every push and pop address.
- `busy_o` starts only on a boundary or return strobe, and ends right after a program-counter load.

Other behaviour is visible only in the directed scenarios: which source wins, the stack bytes and vector contents, the restored context, the non-maskable lock across a return, and the precedence of a return over a coincident request.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_PCH,
    ST_PUSH_PCL,
    ST_PUSH_PSW,
    ST_VEC_LO,
    ST_VEC_HI,
    ST_POP_PSW,
    ST_POP_PCL,
    ST_POP_PCH
  } seq_state_e;
endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IW   = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             ime_i,
  input  logic             nmi_i,
  input  logic             nmi_lock_i,
  output logic             valid_o,
  output logic [IW-1:0]    idx_o,
  output logic             nmi_sel_o
);
  logic [N_SRC-1:0] masked;
  logic             nmi_ok;
  logic             mvalid;
  logic [IW-1:0]    midx;

  assign masked = req_i & en_i;
  assign mvalid = ime_i & (|masked);
  assign nmi_ok = nmi_i & ~nmi_lock_i;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    midx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (masked[i]) midx = IW'(i);
    end
  end

  assign valid_o   = nmi_ok | mvalid;
  assign nmi_sel_o = nmi_ok;
  assign idx_o     = nmi_ok ? IW'(N_SRC) : midx;
endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
  import intr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       boundary_i,
  input  logic       reti_i,
  input  logic       grant_valid_i,
  output seq_state_e state_o,
  output logic       accept_o,
  output logic       start_ret_o
);
  seq_state_e state_q, state_d;
  logic idle;

  assign idle        = (state_q == ST_IDLE);
  assign start_ret_o = idle & reti_i;
  assign accept_o    = idle & boundary_i & grant_valid_i & ~reti_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ret_o)   state_d = ST_POP_PSW;
        else if (accept_o) state_d = ST_PUSH_PCH;
      end
      ST_PUSH_PCH: state_d = ST_PUSH_PCL;
      ST_PUSH_PCL: state_d = ST_PUSH_PSW;
      ST_PUSH_PSW: state_d = ST_VEC_LO;
      ST_VEC_LO:   state_d = ST_VEC_HI;
      ST_VEC_HI:   state_d = ST_IDLE;
      ST_POP_PSW:  state_d = ST_POP_PCL;
      ST_POP_PCL:  state_d = ST_POP_PCH;
      ST_POP_PCH:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/intr_ctx.sv
module intr_ctx
  import intr_pkg::*;
#(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 16,
  localparam int unsigned PCW  = 2 * DW,
  localparam int unsigned IW   = $clog2(N_SRC + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  seq_state_e     state_i,
  input  logic           accept_i,
  input  logic           start_ret_i,
  input  logic [IW-1:0]  grant_idx_i,
  input  logic           grant_nmi_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [DW-1:0]  psw_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [PCW-1:0] pc_q_o,
  output logic [DW-1:0]  psw_q_o,
  output logic [AW-1:0]  sp_q_o,
  output logic [IW-1:0]  idx_q_o,
  output logic           nmi_q_o,
  output logic [DW-1:0]  lo_q_o,
  output logic           nmi_lock_o
);
  logic [PCW-1:0] pc_q;
  logic [DW-1:0]  psw_q, lo_q;
  logic [AW-1:0]  sp_q;
  logic [IW-1:0]  idx_q;
  logic           nmi_q, lock_q;
  logic           push_st, pop_st;

  assign push_st = (state_i == ST_PUSH_PCH) | (state_i == ST_PUSH_PCL) |
                   (state_i == ST_PUSH_PSW);
  assign pop_st  = (state_i == ST_POP_PSW) | (state_i == ST_POP_PCL) |
                   (state_i == ST_POP_PCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      psw_q <= '0;
      idx_q <= '0;
      nmi_q <= 1'b0;
    end else if (accept_i) begin
      pc_q  <= pc_i;
      psw_q <= psw_i;
      idx_q <= grant_idx_i;
      nmi_q <= grant_nmi_i;
    end
  end

  // working stack pointer: one step per push or pop cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sp_q <= '0;
    else if (accept_i | start_ret_i)  sp_q <= sp_i;
    else if (push_st)                 sp_q <= sp_q - 1'b1;
    else if (pop_st)                  sp_q <= sp_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else if ((state_i == ST_VEC_LO) | (state_i == ST_POP_PCL)) lo_q <= mem_rdata_i;
  end

  // NMI lock: set on NMI entry, released when a return completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lock_q <= 1'b0;
    else if (accept_i & grant_nmi_i)  lock_q <= 1'b1;
    else if (state_i == ST_POP_PCH)   lock_q <= 1'b0;
  end

  assign pc_q_o     = pc_q;
  assign psw_q_o    = psw_q;
  assign sp_q_o     = sp_q;
  assign idx_q_o    = idx_q;
  assign nmi_q_o    = nmi_q;
  assign lo_q_o     = lo_q;
  assign nmi_lock_o = lock_q;
endmodule

// File: rtl/intr_seq_top.sv
module intr_seq_top
  import intr_pkg::*;
#(
  parameter int unsigned N_SRC    = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned AW       = 16,
  parameter int unsigned IME_BIT  = 7,
  parameter int unsigned VEC_BASE = 'hFFE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              reti_i,
  input  logic              nmi_i,
  input  logic [N_SRC-1:0]  req_i,
  input  logic [N_SRC-1:0]  en_i,
  output logic [N_SRC-1:0]  req_clr_o,
  output logic              nmi_clr_o,
  input  logic [2*DW-1:0]   pc_i,
  input  logic [DW-1:0]     psw_i,
  input  logic [AW-1:0]     sp_i,
  output logic              pc_we_o,
  output logic [2*DW-1:0]   pc_o,
  output logic              psw_we_o,
  output logic [DW-1:0]     psw_o,
  output logic              sp_we_o,
  output logic [AW-1:0]     sp_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DW-1:0]     mem_wdata_o,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              busy_o
);
  localparam int unsigned PCW = 2 * DW;
  localparam int unsigned IW  = $clog2(N_SRC + 1);
  localparam logic [DW-1:0] IME_MASK = DW'(1) << IME_BIT;

  seq_state_e     state;
  logic           accept, start_ret;
  logic           grant_valid, grant_nmi, nmi_lock;
  logic [IW-1:0]  grant_idx, idx_q;
  logic [PCW-1:0] pc_q;
  logic [DW-1:0]  psw_q, lo_q;
  logic [AW-1:0]  sp_q, vec_addr;
  logic           nmi_q;
  logic           push_st, pop_st;

  intr_arbiter #(.N_SRC(N_SRC)) u_arb (
    .req_i      (req_i),
    .en_i       (en_i),
    .ime_i      (psw_i[IME_BIT]),
    .nmi_i      (nmi_i),
    .nmi_lock_i (nmi_lock),
    .valid_o    (grant_valid),
    .idx_o      (grant_idx),
    .nmi_sel_o  (grant_nmi)
  );

  intr_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .boundary_i    (boundary_i),
    .reti_i        (reti_i),
    .grant_valid_i (grant_valid),
    .state_o       (state),
    .accept_o      (accept),
    .start_ret_o   (start_ret)
  );

  intr_ctx #(.N_SRC(N_SRC), .DW(DW), .AW(AW)) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .accept_i    (accept),
    .start_ret_i (start_ret),
    .grant_idx_i (grant_idx),
    .grant_nmi_i (grant_nmi),
    .pc_i        (pc_i),
    .psw_i       (psw_i),
    .sp_i        (sp_i),
    .mem_rdata_i (mem_rdata_i),
    .pc_q_o      (pc_q),
    .psw_q_o     (psw_q),
    .sp_q_o      (sp_q),
    .idx_q_o     (idx_q),
    .nmi_q_o     (nmi_q),
    .lo_q_o      (lo_q),
    .nmi_lock_o  (nmi_lock)
  );

  assign push_st  = (state == ST_PUSH_PCH) | (state == ST_PUSH_PCL) |
                    (state == ST_PUSH_PSW);
  assign pop_st   = (state == ST_POP_PSW) | (state == ST_POP_PCL) |
                    (state == ST_POP_PCH);
  assign vec_addr = AW'(VEC_BASE) + AW'({idx_q, 1'b0});

  // byte bus
  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_wr_o    = push_st;
    mem_rd_o    = pop_st | (state == ST_VEC_LO) | (state == ST_VEC_HI);
    unique case (state)
      ST_PUSH_PCH: begin mem_addr_o = sp_q; mem_wdata_o = pc_q[PCW-1:DW]; end
      ST_PUSH_PCL: begin mem_addr_o = sp_q; mem_wdata_o = pc_q[DW-1:0];   end
      ST_PUSH_PSW: begin mem_addr_o = sp_q; mem_wdata_o = psw_q;          end
      ST_VEC_LO:   mem_addr_o = vec_addr;
      ST_VEC_HI:   mem_addr_o = vec_addr + 1'b1;
      ST_POP_PSW,
      ST_POP_PCL,
      ST_POP_PCH:  mem_addr_o = sp_q + 1'b1;
      default: ;
    endcase
  end

  // flag clear pulses
  for (genvar k = 0; k < N_SRC; k++) begin : g_clr
    assign req_clr_o[k] = (state == ST_PUSH_PCH) & ~nmi_q & (idx_q == IW'(k));
  end
  assign nmi_clr_o = (state == ST_PUSH_PCH) & nmi_q;

  // core register updates
  assign sp_we_o  = push_st | pop_st;
  assign sp_o     = push_st ? (sp_q - 1'b1) : (sp_q + 1'b1);

  assign psw_we_o = (state == ST_PUSH_PCH) | (state == ST_POP_PSW);
  assign psw_o    = (state == ST_POP_PSW) ? mem_rdata_i : (psw_q & ~IME_MASK);

  assign pc_we_o  = (state == ST_VEC_HI) | (state == ST_POP_PCH);
  assign pc_o     = {mem_rdata_i, lo_q};

  assign busy_o   = (state != ST_IDLE) | accept | start_ret;
endmodule

// File: rtl/intr_seq_chk.sv
module intr_seq_chk #(
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 16,
  parameter int unsigned IME_BIT = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             boundary_i,
  input logic             reti_i,
  input logic [N_SRC-1:0] req_clr_o,
  input logic             nmi_clr_o,
  input logic             pc_we_o,
  input logic             psw_we_o,
  input logic [DW-1:0]    psw_o,
  input logic             sp_we_o,
  input logic [AW-1:0]    sp_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_rd_o,
  input logic             mem_wr_o,
  input logic             busy_o
);
  logic [N_SRC:0] clr_all;
  assign clr_all = {req_clr_o, nmi_clr_o};

  a_r4_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_all));

  a_r4_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_all) |=> !(|clr_all));

  a_r5_ime_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_all) |-> (psw_we_o && !psw_o[IME_BIT]));

  a_r6_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && $past(mem_wr_o)) |-> (mem_addr_o == $past(mem_addr_o) - 1'b1));

  a_r6_push_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_o && mem_wr_o) |-> (sp_o == mem_addr_o - 1'b1));

  a_r10_pop_sp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_we_o && mem_rd_o) |-> (sp_o == mem_addr_o));

  a_r2_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (boundary_i || reti_i));

  a_r8_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(pc_we_o));
endmodule

bind intr_seq_top intr_seq_chk #(
  .N_SRC(N_SRC), .DW(DW), .AW(AW), .IME_BIT(IME_BIT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .reti_i     (reti_i),
  .req_clr_o  (req_clr_o),
  .nmi_clr_o  (nmi_clr_o),
  .pc_we_o    (pc_we_o),
  .psw_we_o   (psw_we_o),
  .psw_o      (psw_o),
  .sp_we_o    (sp_we_o),
  .sp_o       (sp_o),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .busy_o     (busy_o)
);

// File: tb/tb_intr_seq_top.sv
`timescale 1ns/1ps
module tb_intr_seq_top;
  localparam int N = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic          boundary_i = 1'b0, reti_i = 1'b0;
  logic [N-1:0]  en_i = '1;
  logic [N-1:0]  req_clr_o;
  logic          nmi_clr_o;
  logic          pc_we_o, psw_we_o, sp_we_o;
  logic [15:0]   pc_o, sp_o, mem_addr_o;
  logic [7:0]    psw_o, mem_wdata_o, mem_rdata_i;
  logic          mem_rd_o, mem_wr_o, busy_o;

  // core and memory model
  logic [15:0] pc_r, sp_r;
  logic [7:0]  psw_r;
  logic [N-1:0] flags_r;
  logic        nmi_r;
  logic [7:0]  stk [0:255];
  logic [7:0]  vec [0:255];
  logic        h_load = 1'b0;
  logic [15:0] h_pc = '0, h_sp = '0;
  logic [7:0]  h_psw = '0;
  logic [N-1:0] h_flags = '0;
  logic        h_nmi = 1'b0;

  assign mem_rdata_i = (mem_addr_o[15:8] == 8'hFF) ? vec[mem_addr_o[7:0]] : stk[mem_addr_o[7:0]];

  always @(posedge clk_i) begin
    if (h_load) begin
      pc_r <= h_pc; psw_r <= h_psw; sp_r <= h_sp; flags_r <= h_flags; nmi_r <= h_nmi;
    end else begin
      if (pc_we_o)  pc_r  <= pc_o;
      if (psw_we_o) psw_r <= psw_o;
      if (sp_we_o)  sp_r  <= sp_o;
      flags_r <= flags_r & ~req_clr_o;
      if (nmi_clr_o) nmi_r <= 1'b0;
    end
    if (mem_wr_o && mem_addr_o[15:8] != 8'hFF) stk[mem_addr_o[7:0]] <= mem_wdata_o;
  end

  intr_seq_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .boundary_i(boundary_i), .reti_i(reti_i),
    .nmi_i(nmi_r), .req_i(flags_r), .en_i(en_i), .req_clr_o(req_clr_o),
    .nmi_clr_o(nmi_clr_o), .pc_i(pc_r), .psw_i(psw_r), .sp_i(sp_r),
    .pc_we_o(pc_we_o), .pc_o(pc_o), .psw_we_o(psw_we_o), .psw_o(psw_o),
    .sp_we_o(sp_we_o), .sp_o(sp_o), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
    .mem_wr_o(mem_wr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vec_of(input int k);
    return (k == 3) ? 16'hE312 : {8'(8'hA0 + k), 8'(8'h10 + k)};
  endfunction

  task automatic set_core(input logic [15:0] pc, input logic [7:0] psw,
                          input logic [15:0] sp, input logic [N-1:0] fl, input logic nm);
    @(negedge clk_i);
    h_pc = pc; h_psw = psw; h_sp = sp; h_flags = fl; h_nmi = nm; h_load = 1'b1;
    @(negedge clk_i);
    h_load = 1'b0;
  endtask

  // drive a one-cycle strobe, count busy cycles until idle
  task automatic strobe(input logic b, input logic r, output int n);
    n = 0;
    @(negedge clk_i);
    boundary_i = b; reti_i = r;
    #1;
    if (busy_o) n++;
    @(negedge clk_i);
    boundary_i = 1'b0; reti_i = 1'b0;
    while (busy_o && n < 20) begin n++; @(negedge clk_i); end
  endtask

  task automatic t_reset;
    chk("R1 busy", busy_o, 0);
    chk("R1 mem strobes", {mem_wr_o, mem_rd_o}, 0);
    chk("R1 reg strobes", {pc_we_o, psw_we_o, sp_we_o}, 0);
  endtask

  task automatic t_single;
    int n;
    en_i = '1;
    set_core(16'h1234, 8'h85, 16'h01F0, 8'h08, 1'b0);
    strobe(1'b1, 1'b0, n);
    chk("R8 entry busy cycles", n, 6);
    chk("R6 pch at sp", stk[8'hF0], 8'h12);
    chk("R6 pcl at sp-1", stk[8'hEF], 8'h34);
    chk("R6 psw at sp-2", stk[8'hEE], 8'h85);
    chk("R6 sp final", sp_r, 16'h01ED);
    chk("R7 entry pc E312", pc_r, 16'hE312);
    chk("R5 ime cleared", psw_r, 8'h05);
    chk("R4 flag cleared", flags_r, 8'h00);
  endtask

  task automatic t_return;
    int n;
    strobe(1'b0, 1'b1, n);
    chk("R10 return busy cycles", n, 4);
    chk("R10 pc restored", pc_r, 16'h1234);
    chk("R10 psw restored", psw_r, 8'h85);
    chk("R10 sp restored", sp_r, 16'h01F0);
  endtask

  task automatic t_priority;
    int n;
    en_i = 8'hFB;
    set_core(16'h2000, 8'h80, 16'h01F0, 8'h64, 1'b0);
    strobe(1'b1, 1'b0, n);
    chk("R3 lowest enabled wins", pc_r, vec_of(5));
    chk("R4 only winner cleared", flags_r, 8'h44);
    strobe(1'b0, 1'b1, n);
    en_i = '1;
  endtask

  task automatic t_masked;
    int n;
    int seen;
    set_core(16'h3000, 8'h05, 16'h01F0, 8'h10, 1'b0);
    strobe(1'b1, 1'b0, n);
    chk("R2 ime=0 no accept", n, 0);
    chk("R2 ime=0 pc kept", pc_r, 16'h3000);
    chk("R2 ime=0 flag kept", flags_r, 8'h10);
    set_core(16'h3000, 8'h85, 16'h01F0, 8'h10, 1'b0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk_i); if (busy_o) seen++; end
    chk("R2 no boundary no accept", seen, 0);
    chk("R2 no boundary pc kept", pc_r, 16'h3000);
  endtask

  task automatic t_nmi;
    int n;
    set_core(16'h4000, 8'h85, 16'h01F0, 8'h01, 1'b1);
    strobe(1'b1, 1'b0, n);
    chk("R3 nmi beats maskable", pc_r, vec_of(N));
    chk("R4 nmi flag cleared", nmi_r, 0);
    chk("R4 maskable flag kept", flags_r, 8'h01);
    chk("R5 nmi ime cleared", psw_r, 8'h05);
    set_core(pc_r, psw_r, sp_r, flags_r, 1'b1);
    strobe(1'b1, 1'b0, n);
    chk("R9 nmi locked", n, 0);
    chk("R9 nmi still pending", nmi_r, 1);
    strobe(1'b0, 1'b1, n);
    chk("R9 return pc", pc_r, 16'h4000);
    set_core(pc_r, 8'h05, sp_r, 8'h00, 1'b1);
    strobe(1'b1, 1'b0, n);
    chk("R9 nmi accepted after return", pc_r, vec_of(N));
    strobe(1'b0, 1'b1, n);
  endtask

  task automatic t_race_nest;
    int n;
    set_core(16'h5678, 8'h85, 16'h01F0, 8'h08, 1'b0);
    strobe(1'b1, 1'b0, n);
    // software re-enables; source 1 now pending
    set_core(pc_r, 8'h85, sp_r, 8'h02, 1'b0);
    strobe(1'b1, 1'b1, n);
    chk("R11 return wins busy", n, 4);
    chk("R11 return pc", pc_r, 16'h5678);
    chk("R11 request kept", flags_r, 8'h02);
    // nesting: enter 4, then EI with only source 1 enabled
    set_core(16'h6000, 8'h85, 16'h01F0, 8'h10, 1'b0);
    strobe(1'b1, 1'b0, n);
    en_i = 8'h02;
    set_core(pc_r, 8'h85, sp_r, 8'h12, 1'b0);
    strobe(1'b1, 1'b0, n);
    chk("R3 nested enabled source", pc_r, vec_of(1));
    chk("R6 nested sp", sp_r, 16'h01EA);
    chk("R6 nested pch", stk[8'hED], vec_of(4) >> 8);
    chk("R2 disabled flag kept", flags_r, 8'h10);
    strobe(1'b0, 1'b1, n);
    chk("R10 nested return pc", pc_r, vec_of(4));
    strobe(1'b0, 1'b1, n);
    chk("R10 outer return pc", pc_r, 16'h6000);
    chk("R10 outer sp", sp_r, 16'h01F0);
    en_i = '1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin stk[i] = '0; vec[i] = '0; end
    for (int k = 0; k <= N; k++) begin
      vec[8'hE0 + 2*k]     = vec_of(k)[7:0];
      vec[8'hE0 + 2*k + 1] = vec_of(k)[15:8];
    end
    pc_r = '0; psw_r = '0; sp_r = 16'h01F0; flags_r = '0; nmi_r = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_return();
    t_priority();
    t_masked();
    t_nmi();
    t_race_nest();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end
endmodule